// File: doc/BRIEF.md
# Single-Cycle 16-bit Load/Store Processor Core

This block is a small processor core that completes one instruction per clock cycle. Each instruction is a 16-bit word. The core has eight 16-bit general registers and eight operations, encoded in three formats. It fetches the word at the program counter over a combinational instruction-read port. In the same cycle it decodes the word, reads two register operands and computes the result with an adder or a NAND unit. At the next rising edge it commits the register write, any data-memory store and the new program counter.

Every instruction and data address counts 16-bit words, so address n selects the n-th word. Register 0 always reads as zero. A jump-and-link whose 7-bit immediate is non-zero is a system call. The core treats it as a stop: it freezes the program counter and raises its halt output. Only a reset clears that state.

Top module: `core16_cpu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter and every register are cleared to zero and the halt output is cleared. No store is issued while `rst_n` is low.
- R2: Register 0 always reads as zero, even after an instruction names it as a destination.
- R3: Opcode 000 (add) writes R[B]+R[C] into R[A]. Opcode 010 (nand) writes ~(R[B]&R[C]) into R[A]. Register fields: A in bits 12:10, B in bits 9:7, C in bits 2:0. The opcode is in bits 15:13.
- R4: Opcode 001 (addi) writes R[B] plus the sign-extended 7-bit immediate in bits 6:0 into R[A].
- R5: Opcode 011 (lui) writes the 10-bit immediate in bits 9:0 into bits 15:6 of R[A] and clears bits 5:0.
- R6: Opcode 100 (store) drives `dmem_we` high for exactly that cycle. It drives R[A] on `dmem_wdata` and R[B]+simm7 on `dmem_addr`, wrapping modulo 2^16.
- R7: Opcode 101 (load) writes the word read at address R[B]+simm7 into R[A].
- R8: Opcode 110 (branch-if-equal) sets the next PC to PC+1+simm7 when R[A]==R[B], and to PC+1 otherwise. Every other instruction except jump-and-link advances the PC by one.
- R9: Opcode 111 with bits 6:0 zero (jump-and-link) jumps to R[B] and writes PC+1 into R[A]. When A equals B, the target is the value held before the link write.
- R10: Opcode 111 with bits 6:0 non-zero raises `halt` from the next cycle on. After that the PC holds and no register write or store takes place until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 16 | Word address of the instruction being fetched (the PC) |
| imem_data | input | 16 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 16 | Word address for load or store |
| dmem_rdata | input | 16 | Data word at `dmem_addr`, combinational |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store instruction |
| halt | output | 1 | Core stopped by a system-call jump |

## Verification
A single program is the main stimulus. It drives each operation with operands that separate the cases: a negative immediate next to a positive one, an all-ones operand for NAND, a maximal load-upper value, and a store address that wraps below zero. Branches are tried both taken and not taken, and forward and backward. A countdown loop shows whether a wrong offset or a wrong comparison skips or repeats stores. A jump-and-link with the same link and target register tells apart reading the target before or after the link write. A second reset followed by a store of a previously loaded register shows whether reset clears the register file and the halt state.

// File: rtl/core16_pkg.sv
// Package: shared widths, opcode encoding and decoded control bundle for
// the single-cycle core. Assumes a fixed 16-bit word and eight registers.
package core16_pkg;

    parameter int XLEN    = 16;
    parameter int NREG    = 8;
    parameter int RIDX_W  = $clog2(NREG);
    parameter int OP_W    = 3;
    parameter int SIMM_W  = 7;
    parameter int UIMM_W  = 10;
    parameter int LUI_SH  = XLEN - UIMM_W;

    // Opcode encoding: the single place the numbering is defined.
    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'b000,
        OP_ADDI = 3'b001,
        OP_NAND = 3'b010,
        OP_LUI  = 3'b011,
        OP_SW   = 3'b100,
        OP_LW   = 3'b101,
        OP_BEQ  = 3'b110,
        OP_JALR = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_NAND,
        ALU_PASS
    } alu_e;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_MEM,
        WB_LINK
    } wbsel_e;

    typedef struct packed {
        opcode_e           op;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [RIDX_W-1:0] ry;      // second read port: rC or rA
        logic [XLEN-1:0]   imm;
        logic              use_imm;
        alu_e              alu;
        logic              reg_we;
        wbsel_e            wb;
        logic              mem_we;
        logic              is_beq;
        logic              is_jalr;
        logic              is_halt;
    } ctrl_t;

endpackage

// File: rtl/core16_decode.sv
// Module: instruction decoder. Turns one instruction word into a control
// bundle. Purely combinational; assumes the word is valid every cycle.
module core16_decode
    import core16_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    opcode_e            op;
    logic [SIMM_W-1:0]  simm;
    logic [UIMM_W-1:0]  uimm;

    assign op   = opcode_e'(instr[XLEN-1 -: OP_W]);
    assign simm = instr[SIMM_W-1:0];
    assign uimm = instr[UIMM_W-1:0];

    // Purpose: derive all control fields from the opcode and immediates.
    always_comb begin
        ctrl         = '0;
        ctrl.op      = op;
        ctrl.ra      = instr[12:10];
        ctrl.rb      = instr[9:7];
        ctrl.ry      = instr[12:10];
        ctrl.imm     = {{(XLEN-SIMM_W){simm[SIMM_W-1]}}, simm};
        ctrl.alu     = ALU_ADD;
        ctrl.wb      = WB_ALU;
        unique case (op)
            OP_ADD: begin
                ctrl.ry     = instr[RIDX_W-1:0];
                ctrl.reg_we = 1'b1;
            end
            OP_NAND: begin
                ctrl.ry     = instr[RIDX_W-1:0];
                ctrl.alu    = ALU_NAND;
                ctrl.reg_we = 1'b1;
            end
            OP_ADDI: begin
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OP_LUI: begin
                ctrl.imm     = {uimm, {LUI_SH{1'b0}}};
                ctrl.use_imm = 1'b1;
                ctrl.alu     = ALU_PASS;
                ctrl.reg_we  = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_LW: begin
                ctrl.use_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.wb      = WB_MEM;
            end
            OP_BEQ: begin
                ctrl.is_beq = 1'b1;
            end
            OP_JALR: begin
                ctrl.is_halt = (simm != '0);
                ctrl.is_jalr = (simm == '0);
                ctrl.reg_we  = (simm == '0);
                ctrl.wb      = WB_LINK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/core16_regfile.sv
// Module: general register file, two combinational read ports and one
// write port. Entry 0 is hard-wired to zero; all others clear on a
// synchronous active-low reset. Assumes write-before-read is not needed
// within a cycle (reads see the value before the edge).
module core16_regfile #(
    parameter int W    = 16,
    parameter int N    = 8,
    localparam int AW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_x,
    output logic [W-1:0]  rdata_x,
    input  logic [AW-1:0] raddr_y,
    output logic [W-1:0]  rdata_y
);

    logic [N-1:0][W-1:0] regs;

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            // Purpose: hold register i; clear on reset, load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && (waddr == AW'(i)))
                    q <= wdata;
            end
            assign regs[i] = q;
        end
    end

    assign rdata_x = regs[raddr_x];
    assign rdata_y = regs[raddr_y];

endmodule

// File: rtl/core16_alu.sv
// Module: execute unit. Adds, NANDs, or passes the second operand.
// Combinational; wraps modulo 2^W on addition.
module core16_alu
    import core16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    // Purpose: select the result of the requested operation.
    always_comb begin
        unique case (op)
            ALU_NAND: y = ~(a & b);
            ALU_PASS: y = b;
            default:  y = a + b;
        endcase
    end

endmodule

// File: rtl/core16_cpu.sv
// Module: single-cycle core top. Fetch, decode, register read, execute,
// memory access and write-back all happen within one clock cycle. State
// (PC, registers, halt flag) updates on the rising edge. Assumes both
// memory ports return read data combinationally for the address driven
// in the same cycle. Reset is synchronous and active-low.
module core16_cpu
    import core16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            halt
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] br_target;
    logic            halted_q;
    logic            active;
    ctrl_t           ctrl;
    logic [XLEN-1:0] opx;
    logic [XLEN-1:0] opy;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] wb_data;
    logic            operands_equal;

    assign active = rst_n && !halted_q;

    core16_decode u_decode (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    core16_regfile #(
        .W (XLEN),
        .N (NREG)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl.reg_we && active),
        .waddr   (ctrl.ra),
        .wdata   (wb_data),
        .raddr_x (ctrl.rb),
        .rdata_x (opx),
        .raddr_y (ctrl.ry),
        .rdata_y (opy)
    );

    assign alu_b = ctrl.use_imm ? ctrl.imm : opy;

    core16_alu #(
        .W (XLEN)
    ) u_alu (
        .op (ctrl.alu),
        .a  (opx),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign pc_inc         = pc_q + XLEN'(1);
    assign br_target      = pc_inc + ctrl.imm;
    assign operands_equal = (opx == opy);

    // Purpose: choose the value committed to the destination register.
    always_comb begin
        unique case (ctrl.wb)
            WB_MEM:  wb_data = dmem_rdata;
            WB_LINK: wb_data = pc_inc;
            default: wb_data = alu_y;
        endcase
    end

    // Purpose: choose the next program counter.
    always_comb begin
        if (ctrl.is_halt)
            pc_next = pc_q;
        else if (ctrl.is_jalr)
            pc_next = opx;
        else if (ctrl.is_beq && operands_equal)
            pc_next = br_target;
        else
            pc_next = pc_inc;
    end

    // Purpose: program counter and halt flag, frozen once halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            pc_q     <= pc_next;
            halted_q <= ctrl.is_halt;
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = opy;
    assign dmem_we    = ctrl.mem_we && active;
    assign halt       = halted_q;

endmodule

// File: rtl/core16_cpu_chk.sv
// Module: property checker for the core, attached by bind. Observes only
// the top-level ports and re-decodes the fetched word independently.
module core16_cpu_chk
    import core16_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_data,
    input logic [XLEN-1:0] dmem_addr,
    input logic [XLEN-1:0] dmem_wdata,
    input logic            dmem_we,
    input logic            halt
);

    logic [2:0]      f_op;
    logic [6:0]      f_imm;
    logic [XLEN-1:0] f_off;

    assign f_op  = imem_data[15:13];
    assign f_imm = imem_data[6:0];
    assign f_off = {{(XLEN-7){f_imm[6]}}, f_imm};

    // R1: first cycle out of reset fetches from word 0 with halt low
    p_reset_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (imem_addr == '0) && !halt);

    // R6: a store strobe only appears for the store opcode
    p_store_only_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (f_op == 3'b100));

    // R8: non-control instructions advance the PC by one
    p_seq_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && f_op != 3'b110 && f_op != 3'b111)
        |=> imem_addr == $past(imem_addr) + 16'd1);

    // R8: a branch lands on PC+1 or PC+1+offset
    p_branch_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && f_op == 3'b110)
        |=> (imem_addr == $past(imem_addr) + 16'd1) ||
            (imem_addr == $past(imem_addr) + 16'd1 + $past(f_off)));

    // R10: a system-call jump raises halt on the next cycle
    p_halt_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && f_op == 3'b111 && f_imm != '0) |=> halt);

    // R10: halt is sticky and freezes the PC
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt && $stable(imem_addr));

    // R10: no stores while halted
    p_halt_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !dmem_we);

    // R1: no store strobe while reset is applied
    always_comb begin
        if (!rst_n) a_reset_no_store_r1: assert (!dmem_we || $isunknown(dmem_we));
    end

endmodule

bind core16_cpu core16_cpu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .halt       (halt)
);

// File: tb/core16_cpu_tb.sv
// Scoreboard bench: the driver loads a program and queues the stores it
// must produce; a monitor pops and compares every store the core issues.
module core16_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, imem_data, dmem_addr, dmem_rdata, dmem_wdata;
    logic        dmem_we, halt;

    logic [15:0] imem [64];
    logic [15:0] dmem [64];

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q [$];

    always #2 clk = ~clk;  // 250 MHz

    assign imem_data  = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[5:0]];

    core16_cpu u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .halt       (halt)
    );

    // Purpose: bench data memory write.
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

    function automatic logic [15:0] rrr(input logic [2:0] op, input int a, input int b, input int c);
        return {op, 3'(a), 3'(b), 4'b0, 3'(c)};
    endfunction
    function automatic logic [15:0] rri(input logic [2:0] op, input int a, input int b, input int imm);
        return {op, 3'(a), 3'(b), 7'(imm)};
    endfunction
    function automatic logic [15:0] ri(input logic [2:0] op, input int a, input int imm);
        return {op, 3'(a), 10'(imm)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] a, input logic [15:0] d, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Purpose: monitor; compare each issued store against the queue head.
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected store actual=%h@%h expected=none", dmem_wdata, dmem_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " addr"}, dmem_addr, e.addr);
                check({e.tag, " data"}, dmem_wdata, e.data);
            end
        end
    end

    task automatic wait_halt(input string tag);
        int n = 0;
        while (!halt && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (!halt) begin
            checks++; errors++;
            $display("FAIL %s watchdog actual=running expected=halt", tag);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end
        dmem[20] = 16'h1234;
        imem[0]  = rri(3'b001, 1, 0, 5);        // addi r1 = 5
        imem[1]  = rri(3'b001, 2, 0, -1);       // addi r2 = ffff
        imem[2]  = rrr(3'b000, 3, 1, 2);        // add r3 = 4
        imem[3]  = rri(3'b100, 3, 0, 10);
        imem[4]  = rrr(3'b010, 4, 1, 1);        // nand r4 = fffa
        imem[5]  = rri(3'b100, 4, 0, 11);
        imem[6]  = ri (3'b011, 5, 10'h3FF);     // lui r5 = ffc0
        imem[7]  = rri(3'b100, 5, 0, 12);
        imem[8]  = rri(3'b001, 0, 0, 7);        // write to r0
        imem[9]  = rri(3'b100, 0, 0, 13);
        imem[10] = rri(3'b100, 2, 1, -64);      // addr 5-64 wraps
        imem[11] = rri(3'b101, 6, 0, 20);       // load r6
        imem[12] = rri(3'b100, 6, 0, 14);
        imem[13] = rri(3'b110, 1, 2, 5);        // not taken
        imem[14] = rri(3'b100, 1, 0, 15);
        imem[15] = rri(3'b110, 1, 1, 1);        // taken, skip 16
        imem[16] = rri(3'b100, 1, 0, 16);
        imem[17] = rri(3'b001, 7, 0, 21);
        imem[18] = rri(3'b111, 7, 7, 0);        // jalr r7,r7
        imem[19] = rri(3'b100, 0, 0, 17);
        imem[20] = rri(3'b100, 0, 0, 17);
        imem[21] = rri(3'b100, 7, 0, 18);
        imem[22] = rri(3'b001, 1, 1, -1);       // loop
        imem[23] = rri(3'b100, 1, 0, 19);
        imem[24] = rri(3'b110, 1, 0, 1);
        imem[25] = rri(3'b110, 0, 0, -4);
        imem[26] = rri(3'b111, 0, 0, 1);        // halt
        imem[27] = rri(3'b100, 0, 0, 30);

        push_exp(16'd10,   16'h0004, "R3 add");
        push_exp(16'd11,   16'hFFFA, "R3 nand");
        push_exp(16'd12,   16'hFFC0, "R5 lui");
        push_exp(16'd13,   16'h0000, "R2 zero reg");
        push_exp(16'hFFC5, 16'hFFFF, "R6 wrap R4 negimm");
        push_exp(16'd14,   16'h1234, "R7 load");
        push_exp(16'd15,   16'h0005, "R8 not taken");
        push_exp(16'd18,   16'd19,   "R9 link target");
        for (int k = 4; k >= 0; k--) push_exp(16'd19, 16'(k), "R8 loop");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", imem_addr, 16'd0);
        check("R1 reset halt", {15'd0, halt}, 16'd0);
        check("R1 reset store", {15'd0, dmem_we}, 16'd0);
        rst_n = 1'b1;

        wait_halt("R10");
        check("R10 halt pc", imem_addr, 16'd26);
        check("R10 queue drained", 16'(exp_q.size()), 16'd0);
        repeat (8) @(negedge clk);
        check("R10 pc held", imem_addr, 16'd26);
        check("R10 halt held", {15'd0, halt}, 16'd1);

        // Second run: reset must clear registers and halt.
        rst_n = 1'b0;
        imem[0] = rri(3'b100, 6, 0, 40);        // store r6, expect 0
        imem[1] = rri(3'b111, 0, 0, 2);
        push_exp(16'd40, 16'h0000, "R1 regs cleared");
        @(posedge clk);
        @(negedge clk);
        check("R1 halt cleared", {15'd0, halt}, 16'd0);
        check("R1 pc cleared", imem_addr, 16'd0);
        rst_n = 1'b1;
        wait_halt("R10 second");
        check("R10 second halt pc", imem_addr, 16'd1);
        check("R1 queue drained", 16'(exp_q.size()), 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule